// File: doc/BRIEF.md
# Sawtooth PWM Timer Channel

This block is one timer channel with two PWM pins. A single up-counter is clocked through a prescaler that divides by a power of four. Each prescaled tick advances the counter from zero to a programmed period value, and the next tick wraps it back to zero. That wrap marks the end of a cycle. Two compare values, one for each pin, are checked against the shared counter. A 5-bit code for each pin sets the pin's level when the counter starts, what happens to it at cycle end and what happens to it on a compare match. From these events each pin builds its waveform.

Software reaches the channel through a 32-bit register port. Writes take effect at the clock edge. Reads are combinational from the address. One start bit runs or stops the counter, and so both pins together. Mode and prescaler settings can only be changed while the counter is stopped.

Top module: `pwm_saw_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and both pins and both enable qualifiers are low.
- R2: The register byte offsets are as follows. Control is at 0x00: start at bit 0, mode at 18:16, prescaler at 26:24. Direction is at 0x04, bits 1:0. Pin control is at 0x08: code A at 4:0, enable A at 8, code B at 20:16, enable B at 24. The counter is at 0x0C, compare A at 0x10, compare B at 0x14 and period at 0x18. Writable fields read back what was written, and all other bits read 0.
- R3: Prescaler code n in the range 0 to 5 advances the counter once every 4^n clocks of running time. Codes 6 and 7 behave like code 5 (divide by 1024).
- R4: While the start bit is set, writes to the mode and prescaler fields are ignored. The start bit itself still takes the written value.
- R5: While running in mode 0, the counter rises by one on each prescaled tick. When stopped, or in any other mode, it holds its value. A write to the counter offset loads it directly.
- R6: A tick that finds the counter at or above the period value sets the counter to 0. This is the cycle-end event, so one PWM cycle lasts period+1 ticks.
- R7: Pin code bit 4 is the start level. Bits 3:2 are the cycle-end action and bits 1:0 the compare-match action, each one of 00 hold, 01 drive low, 10 drive high, 11 toggle. So code 0x1B starts high, goes high at cycle end and toggles on a match. Code 0x07 starts low, goes low at cycle end and toggles on a match.
- R8: A control write that sets the start bit while the counter is stopped loads each pin's level with its start level.
- R9: A compare match is a tick on which the counter equals that pin's compare value. When a match and cycle end fall on the same tick, the cycle-end action wins. A compare value above the period never matches.
- R10: Each pin's enable qualifier mirrors its enable bit. A pin is low whenever its enable bit is clear or the start bit is clear.
- R11: Both pins use the one counter, period and start bit, but each has its own compare value and code.
- R12: The direction register is stored and read back but has no effect on counting, which is always upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_a | output | 1 | Pin A level |
| pwm_a_oe | output | 1 | Pin A enable qualifier |
| pwm_b | output | 1 | Pin B level |
| pwm_b_oe | output | 1 | Pin B enable qualifier |

## Verification
A register write lands at the rising edge within its strobe, and read data follows the address with no delay. The start bit is seen at the first falling edge after its write, with the counter still at its loaded value. From there a divide-by-one counter shows value k at the k-th falling edge, and each pin shows the level produced by the tick at the edge before. With a divisor d, the counter first changes between falling edges d-1 and d after the start. The bench drives and samples only on falling edges and counts edges from the return of the start write. Each expected counter value and pin level is therefore derived from that edge count, the period and the compare values.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;

   // register byte offsets
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_DIR  = 'h04;
   localparam int OFS_PINS = 'h08;
   localparam int OFS_CNT  = 'h0C;
   localparam int OFS_CMP0 = 'h10;   // pin i compare at OFS_CMP0 + 4*i
   localparam int OFS_PER  = 'h18;

   // control fields
   localparam int CTRL_RUN_BIT = 0;
   localparam int MODE_LSB     = 16;
   localparam int MODE_W       = 3;
   localparam int PSC_LSB      = 24;
   localparam int PSC_W        = 3;
   localparam int DIR_W        = 2;
   localparam logic [MODE_W-1:0] MODE_SAW = '0;

   // pin control fields
   localparam int PIN_CODE_W = 5;
   localparam int PIN_STRIDE = 16;
   localparam int PIN_EN_OFS = 8;
   localparam int NUM_PINS   = 2;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } pin_act_e;

   typedef struct packed {
      logic     init_lvl;   // bit 4
      pin_act_e end_act;    // bits 3:2
      pin_act_e cmp_act;    // bits 1:0
   } pin_code_t;

   function automatic logic apply_act(input pin_act_e act, input logic cur);
      case (act)
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/pwm_saw_prescaler.sv
module pwm_saw_prescaler #(
   parameter int CODE_W    = 3,
   parameter int MAX_CODE  = 5,
   parameter int STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int DIV_W = MAX_CODE * STEP_LOG2;

   if (MAX_CODE < 1 || DIV_W > 30 || STEP_LOG2 < 1) begin : g_bad_div
      $error("pwm_saw_prescaler: divider range out of bounds");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("pwm_saw_prescaler: MAX_CODE does not fit CODE_W");
   end

   logic [CODE_W-1:0] code_c;
   logic [31:0]       div_full;
   logic [DIV_W-1:0]  div_m1;
   logic [DIV_W-1:0]  p_cnt;

   always_comb begin
      code_c   = (int'(code) > MAX_CODE) ? CODE_W'(MAX_CODE) : code;
      div_full = (32'd1 << (STEP_LOG2 * int'(code_c))) - 32'd1;
      div_m1   = div_full[DIV_W-1:0];
   end

   assign tick = run && (p_cnt == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              p_cnt <= '0;
      else if (!run || tick)   p_cnt <= '0;
      else                     p_cnt <= p_cnt + 1'b1;
   end

   // R3: the divider count never passes the selected terminal value
   p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (p_cnt <= div_m1));

endmodule

// File: rtl/pwm_saw_counter.sv
module pwm_saw_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] period,
   input  logic             sw_we,
   input  logic [CNT_W-1:0] sw_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = step && (cnt >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (sw_we)  cnt <= sw_val;
      else if (wrap)   cnt <= '0;
      else if (step)   cnt <= cnt + 1'b1;
   end

   p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !sw_we) |=> (cnt == '0));

   p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wrap && !sw_we) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !sw_we) |=> $stable(cnt));

endmodule

// File: rtl/pwm_saw_pin.sv
module pwm_saw_pin
   import pwm_saw_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PIN_CODE_W-1:0] code,
   input  logic                  en,
   input  logic                  run,
   input  logic                  load,
   input  logic                  step,
   input  logic                  wrap,
   input  logic [CNT_W-1:0]      cnt,
   input  logic [CNT_W-1:0]      cmp,
   output logic                  pin,
   output logic                  pin_en
);
   pin_code_t pc;
   logic      match;
   logic      level_q;

   assign pc    = pin_code_t'(code);
   assign match = step && !wrap && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      level_q <= 1'b0;
      else if (load)   level_q <= pc.init_lvl;
      else if (wrap)   level_q <= apply_act(pc.end_act, level_q);
      else if (match)  level_q <= apply_act(pc.cmp_act, level_q);
   end

   assign pin    = en && run && level_q;
   assign pin_en = en;

   p_load_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (level_q == $past(pc.init_lvl)));

   p_end_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !load && pc.end_act == ACT_HIGH) |=> level_q);

   p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !match && !load) |=> $stable(level_q));

endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
   import pwm_saw_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int ADDR_W        = 8,
   parameter int PSC_MAX_CODE  = 5,
   parameter int PSC_STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              pwm_a,
   output logic              pwm_a_oe,
   output logic              pwm_b,
   output logic              pwm_b_oe
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("pwm_saw_timer: CNT_W must be 2..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pwm_saw_timer: ADDR_W too small for register map");
   end

   logic                  run_q;
   logic [MODE_W-1:0]     mode_q;
   logic [PSC_W-1:0]      psc_q;
   logic [DIR_W-1:0]      dir_q;
   logic [CNT_W-1:0]      per_q;
   logic [PIN_CODE_W-1:0] code_q [NUM_PINS];
   logic                  en_q   [NUM_PINS];
   logic [CNT_W-1:0]      cmp_q  [NUM_PINS];
   logic                  pin_o  [NUM_PINS];
   logic                  pin_oe [NUM_PINS];

   logic                  wr_ctrl, wr_cnt, load, tick, step, wrap;
   logic [CNT_W-1:0]      cnt;
   logic                  unused_wdata;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_CNT));
   assign load    = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !run_q;
   assign step    = tick && (mode_q == MODE_SAW);
   assign unused_wdata = ^bus_wdata;

   // shared channel registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= '0;
         psc_q  <= '0;
         dir_q  <= '0;
         per_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            run_q <= bus_wdata[CTRL_RUN_BIT];
            if (!run_q) begin
               mode_q <= bus_wdata[MODE_LSB +: MODE_W];
               psc_q  <= bus_wdata[PSC_LSB +: PSC_W];
            end
         end
         if (bus_addr == ADDR_W'(OFS_DIR)) dir_q <= bus_wdata[DIR_W-1:0];
         if (bus_addr == ADDR_W'(OFS_PER)) per_q <= bus_wdata[CNT_W-1:0];
      end
   end

   pwm_saw_prescaler #(
      .CODE_W    (PSC_W),
      .MAX_CODE  (PSC_MAX_CODE),
      .STEP_LOG2 (PSC_STEP_LOG2)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .code  (psc_q),
      .tick  (tick)
   );

   pwm_saw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .period (per_q),
      .sw_we  (wr_cnt),
      .sw_val (bus_wdata[CNT_W-1:0]),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   // per-pin registers and waveform generators
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int CODE_LSB = i * PIN_STRIDE;
      localparam int EN_BIT   = i * PIN_STRIDE + PIN_EN_OFS;
      localparam int CMP_OFS  = OFS_CMP0 + 4 * i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[i] <= '0;
            en_q[i]   <= 1'b0;
            cmp_q[i]  <= '0;
         end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_PINS)) begin
               code_q[i] <= bus_wdata[CODE_LSB +: PIN_CODE_W];
               en_q[i]   <= bus_wdata[EN_BIT];
            end
            if (bus_addr == ADDR_W'(CMP_OFS)) cmp_q[i] <= bus_wdata[CNT_W-1:0];
         end
      end

      pwm_saw_pin #(.CNT_W(CNT_W)) u_pin (
         .clk    (clk),
         .rst_n  (rst_n),
         .code   (code_q[i]),
         .en     (en_q[i]),
         .run    (run_q),
         .load   (load),
         .step   (step),
         .wrap   (wrap),
         .cnt    (cnt),
         .cmp    (cmp_q[i]),
         .pin    (pin_o[i]),
         .pin_en (pin_oe[i])
      );
   end

   assign pwm_a    = pin_o[0];
   assign pwm_a_oe = pin_oe[0];
   assign pwm_b    = pin_o[1];
   assign pwm_b_oe = pin_oe[1];

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[CTRL_RUN_BIT]          = run_q;
         bus_rdata[MODE_LSB +: MODE_W]    = mode_q;
         bus_rdata[PSC_LSB +: PSC_W]      = psc_q;
      end
      if (bus_addr == ADDR_W'(OFS_DIR))  bus_rdata[DIR_W-1:0] = dir_q;
      if (bus_addr == ADDR_W'(OFS_PINS)) begin
         for (int i = 0; i < NUM_PINS; i++) begin
            bus_rdata[i*PIN_STRIDE +: PIN_CODE_W]     = code_q[i];
            bus_rdata[i*PIN_STRIDE + PIN_EN_OFS]      = en_q[i];
         end
      end
      if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata[CNT_W-1:0] = cnt;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (bus_addr == ADDR_W'(OFS_CMP0 + 4 * i)) bus_rdata[CNT_W-1:0] = cmp_q[i];
      end
      if (bus_addr == ADDR_W'(OFS_PER))  bus_rdata[CNT_W-1:0] = per_q;
   end

   // R4: configuration is frozen while the counter runs
   p_cfg_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> ($stable(mode_q) && $stable(psc_q)));

endmodule

// File: tb/tb_pwm_saw_timer.sv
module tb_pwm_saw_timer;
   localparam logic [7:0] A_CTRL = 8'h00, A_DIR = 8'h04, A_PINS = 8'h08,
                          A_CNT = 8'h0C, A_CMPA = 8'h10, A_CMPB = 8'h14,
                          A_PER = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_a, pwm_a_oe, pwm_b, pwm_b_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   pwm_saw_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_a(pwm_a), .pwm_a_oe(pwm_a_oe), .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // returns at the falling edge just after the write took effect
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      logic [7:0] regs [7] = '{A_CTRL, A_DIR, A_PINS, A_CNT, A_CMPA, A_CMPB, A_PER};
      foreach (regs[i]) begin
         rd(regs[i], v);
         chk("R1", "reg after reset", v, 32'h0);
      end
      chk("R1", "pins after reset", {28'h0, pwm_a, pwm_a_oe, pwm_b, pwm_b_oe}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_PINS, 32'hFFFF_FFFF); rd(A_PINS, v); chk("R2", "pin ctrl mask", v, 32'h011F_011F);
      wr(A_DIR, 32'hFFFF_FFFF);  rd(A_DIR, v);  chk("R12", "direction mask", v, 32'h3);
      wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk("R2", "control mask", v, 32'h0707_0000);
      wr(A_CTRL, 32'h0);
      wr(A_CMPA, 32'hDEAD_0001); rd(A_CMPA, v); chk("R2", "compare A", v, 32'hDEAD_0001);
      wr(A_CMPB, 32'h1234_5678); rd(A_CMPB, v); chk("R2", "compare B", v, 32'h1234_5678);
      wr(A_PER, 32'hCAFE_0042);  rd(A_PER, v);  chk("R2", "period", v, 32'hCAFE_0042);
      wr(A_CNT, 32'h55);         rd(A_CNT, v);  chk("R5", "counter load", v, 32'h55);
      wr(A_PINS, 32'h0);
   endtask

   // R7 R11: codes 0x1B and 0x07 on a shared period 9
   task automatic t_basic_pwm();
      logic [31:0] v, v2;
      wr(A_PER, 9); wr(A_CMPA, 3); wr(A_CMPB, 6);
      wr(A_PINS, 32'h0107_011B); wr(A_CNT, 0); wr(A_DIR, 3);
      wr(A_CTRL, 1);
      for (int k = 0; k < 20; k++) begin
         rd(A_CNT, v);
         chk("R6", "counter sequence", v, k % 10);
         chk("R7", "pin A 0x1B", pwm_a, ((k % 10) <= 3));
         chk("R11", "pin B 0x07", pwm_b, ((k % 10) >= 7));
         @(negedge clk);
      end
      chk("R10", "oe both", {pwm_a_oe, pwm_b_oe}, 2'b11);
      wr(A_CTRL, 0);
      chk("R10", "pins low after stop", {pwm_a, pwm_b}, 2'b00);
      rd(A_CNT, v);
      repeat (5) @(negedge clk);
      rd(A_CNT, v2);
      chk("R5", "stopped counter holds", v2, v);
   endtask

   task automatic t_lock();
      logic [31:0] v, v2;
      wr(A_PER, 1000); wr(A_CNT, 0); wr(A_CTRL, 1);
      wr(A_CTRL, 32'h0302_0001);
      rd(A_CTRL, v);
      chk("R4", "mode/psc ignored while running", v, 32'h1);
      rd(A_CNT, v);
      @(negedge clk);
      rd(A_CNT, v2);
      chk("R4", "still counting by one", v2, v + 1);
      wr(A_CTRL, 0);
   endtask

   task automatic t_psc(input int code, input int div);
      logic [31:0] v;
      wr(A_CTRL, 0); wr(A_PER, 32'hFFFF_FFFF); wr(A_CNT, 0);
      wr(A_CTRL, (code << 24) | 1);
      repeat (div - 1) @(negedge clk);
      rd(A_CNT, v); chk("R3", $sformatf("code %0d before tick", code), v, 0);
      @(negedge clk);
      rd(A_CNT, v); chk("R3", $sformatf("code %0d first tick", code), v, 1);
      repeat (div) @(negedge clk);
      rd(A_CNT, v); chk("R3", $sformatf("code %0d second tick", code), v, 2);
      wr(A_CTRL, 0);
   endtask

   task automatic t_mode();
      logic [31:0] v;
      wr(A_CTRL, 0); wr(A_PER, 100);
      wr(A_CTRL, 32'h0001_0000); wr(A_CNT, 5); wr(A_CTRL, 32'h0001_0001);
      repeat (10) @(negedge clk);
      rd(A_CNT, v); chk("R5", "non-sawtooth mode holds", v, 5);
      wr(A_CTRL, 0); wr(A_CTRL, 0);
   endtask

   task automatic t_priority();
      wr(A_PER, 5); wr(A_CMPA, 5); wr(A_CMPB, 8);
      wr(A_PINS, 32'h0107_011B); wr(A_CNT, 0); wr(A_CTRL, 1);
      for (int k = 0; k < 14; k++) begin
         chk("R9", "end beats match on A", pwm_a, 1);
         chk("R9", "compare above period on B", pwm_b, 0);
         @(negedge clk);
      end
      wr(A_CTRL, 0);
   endtask

   task automatic t_codes();
      logic [31:0] v;
      wr(A_PER, 3); wr(A_CMPA, 1); wr(A_CMPB, 0);
      wr(A_PINS, 32'h0110_010E); wr(A_CNT, 0); wr(A_CTRL, 1);
      for (int k = 0; k < 12; k++) begin
         chk("R7", "code 0x0E on A", pwm_a, ((k % 4) >= 2));
         chk("R8", "code 0x10 start high hold on B", pwm_b, 1);
         @(negedge clk);
      end
      wr(A_PINS, 32'h0110_000E);
      for (int k = 0; k < 6; k++) begin
         chk("R10", "disabled A low", {pwm_a, pwm_a_oe}, 2'b00);
         chk("R10", "B unaffected", {pwm_b, pwm_b_oe}, 2'b11);
         @(negedge clk);
      end
      wr(A_CTRL, 0);
      chk("R10", "B low when stopped", pwm_b, 0);
      // start from a counter above the period: wraps on first tick
      wr(A_PER, 9); wr(A_CNT, 20); wr(A_CTRL, 1);
      rd(A_CNT, v); chk("R6", "start value kept", v, 20);
      @(negedge clk);
      rd(A_CNT, v); chk("R6", "above period wraps", v, 0);
      wr(A_CTRL, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_basic_pwm();
      t_lock();
      t_psc(0, 1);
      t_psc(1, 4);
      t_psc(2, 16);
      t_psc(5, 1024);
      t_psc(7, 1024);
      t_mode();
      t_priority();
      t_codes();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule